// File: doc/BRIEF.md
# Serial Sampling Converter Output Responder

This block is the digital side of a serial sampling converter. A bus master drives an active-low select and a serial clock into it. The block answers on a serial data line that can be put in a high-impedance state. When the select falls, the block takes a parallel sample word and starts a conversion. It then sends that word inside a fixed frame and steps through the conversion and acquisition phases as clock edges arrive. Its main use is as a synthesizable stand-in for the converter, so a master design can be checked against device-accurate timing and abort rules.

Both select and serial clock are sampled in the system clock domain and edges are found there, so every response follows the stimulus by one system clock. The high-impedance state is shown as a separate enable output. The block also reports, each as a one-cycle pulse, whether a conversion finished or was aborted. It shows whether the current frame and the next frame carry valid data.

Top module: `sadc_out_if`

## Requirements
- R1: After synchronous reset, `sdo_oe`, `sdo`, `conv_done` and `conv_abort` are 0 and `next_valid` is 1.
- R2: `sdo_oe` goes to 1 one system clock after `cs_n` is seen low and to 0 one system clock after `cs_n` is seen high.
- R3: The frame starts with two zero bits: one while no serial clock falling edge has yet been counted, and one after the 1st falling edge.
- R4: After falling edges 2 through 11 the line carries the sample latched at the select falling edge, MSB first. Changes on `sample_in` after that edge have no effect on the frame.
- R5: From the 12th falling edge onward, including edges past the 16th, the line carries 0.
- R6: `conv_done` pulses for one cycle on the first serial clock rising edge after the 11th falling edge, and `next_valid` is then 1.
- R7: `cs_n` rising before that conversion-end point pulses `conv_abort` for one cycle and clears `next_valid`.
- R8: A frame that starts while `next_valid` is 0 has `frame_valid` 0 and sends all zeros in its data slots. If that frame runs to the conversion-end point, `next_valid` is set again.
- R9: `cs_n` rising after the conversion-end point produces no abort pulse and leaves `next_valid` at 1.
- R10: Whenever `sdo_oe` is 0, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master, idle high |
| sample_in | input | DATA_W | Parallel sample, latched at the select falling edge |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for sdo (0 means high impedance) |
| conv_done | output | 1 | One-cycle pulse when a conversion completes |
| conv_abort | output | 1 | One-cycle pulse when a conversion is cut short |
| next_valid | output | 1 | The next frame will carry valid data |
| frame_valid | output | 1 | The current frame carries valid data |

## Verification
The bench runs frames with serial clock counts of 0, 1, 2, 10, 11, 12, 16 and 20 falling edges. This covers the boundary between 10 edges (an abort) and 11 edges (a completed conversion). A design that counts the conversion end one edge off would flag an abort or a completion on the wrong side of that boundary. Runs past 16 edges show whether the counter wraps and sends data a second time. Each abort is followed by a frame that must send only zeros. A frame that runs to completion must then bring valid data back, which catches a validity flag that sticks in either state. A sweep over many sample values, with `sample_in` changed right after the select falls, catches bit-order mistakes and a sample that is not held for the whole frame.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } phase_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_fall;
        logic sck_rise;
    } edges_t;

    // Bit placed on the line after k counted falling edges.
    function automatic logic pick_bit(input int unsigned k,
                                      input int unsigned lead,
                                      input int unsigned dw,
                                      input logic [31:0] word);
        if (k >= lead && k < lead + dw)
            return word[dw - 1 - (k - lead)];
        return 1'b0;
    endfunction

endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det
    import sadc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sclk,
    output edges_t ev
);
    logic cs_q;
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b1;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sclk;
        end
    end

    always_comb begin
        ev.cs_fall  = cs_q & ~cs_n;
        ev.cs_rise  = ~cs_q & cs_n;
        ev.sck_fall = sck_q & ~sclk;
        ev.sck_rise = ~sck_q & sclk;
    end
endmodule

// File: rtl/sadc_frame_ctr.sv
module sadc_frame_ctr #(
    parameter int CNT_W = 5,
    parameter int LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (step && cnt < TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sadc_phase_ctl.sv
module sadc_phase_ctl
    import sadc_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int END_IDX = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  edges_t           ev,
    input  logic [CNT_W-1:0] cnt,
    output phase_e           phase,
    output logic             next_valid,
    output logic             frame_valid,
    output logic             conv_done,
    output logic             conv_abort
);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(END_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            next_valid  <= 1'b1;
            frame_valid <= 1'b0;
            conv_done   <= 1'b0;
            conv_abort  <= 1'b0;
        end else begin
            conv_done  <= 1'b0;
            conv_abort <= 1'b0;
            if (ev.cs_rise) begin
                if (phase == PH_CONV) begin
                    conv_abort <= 1'b1;
                    next_valid <= 1'b0;
                end
                phase <= PH_IDLE;
            end else if (ev.cs_fall) begin
                phase       <= PH_CONV;
                frame_valid <= next_valid;
            end else if (phase == PH_CONV && ev.sck_rise && cnt >= END_CNT) begin
                phase      <= PH_ACQ;
                conv_done  <= 1'b1;
                next_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sadc_out_if.sv
module sadc_out_if
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LEAD_ZEROS  = 2,
    parameter int TRAIL_ZEROS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_done,
    output logic              conv_abort,
    output logic              next_valid,
    output logic              frame_valid
);
    localparam int FRAME_LEN = LEAD_ZEROS + DATA_W + TRAIL_ZEROS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int END_IDX   = LEAD_ZEROS + DATA_W - 1;

    edges_t            ev;
    logic [CNT_W-1:0]  cnt;
    phase_e            phase;
    logic [DATA_W-1:0] data_q;

    sadc_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .ev   (ev)
    );

    sadc_frame_ctr #(.CNT_W(CNT_W), .LIMIT(FRAME_LEN)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .start (ev.cs_fall),
        .step  (ev.sck_fall),
        .cnt   (cnt)
    );

    sadc_phase_ctl #(.CNT_W(CNT_W), .END_IDX(END_IDX)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .cnt         (cnt),
        .phase       (phase),
        .next_valid  (next_valid),
        .frame_valid (frame_valid),
        .conv_done   (conv_done),
        .conv_abort  (conv_abort)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (ev.cs_fall)
            data_q <= sample_in;
    end

    assign sdo_oe = (phase != PH_IDLE);
    assign sdo    = sdo_oe & frame_valid &
                    pick_bit(32'(cnt), LEAD_ZEROS, DATA_W, 32'(data_q));
endmodule

// File: rtl/sadc_out_if_chk.sv
module sadc_out_if_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sdo,
    input logic sdo_oe,
    input logic conv_done,
    input logic conv_abort,
    input logic next_valid
);
    assert_oe_on_select_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> sdo_oe);

    assert_oe_off_select_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> !sdo_oe);

    assert_first_bit_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> !sdo);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done);

    assert_done_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> next_valid);

    assert_abort_clears_valid_R7: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> !next_valid);

    assert_abort_needs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> $past(cs_n));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);
endmodule

bind sadc_out_if sadc_out_if_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .conv_done  (conv_done),
    .conv_abort (conv_abort),
    .next_valid (next_valid)
);

// File: tb/sadc_out_if_test.sv
module sadc_out_if_test;
    localparam int DW = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          sdo, sdo_oe, conv_done, conv_abort, next_valid, frame_valid;

    sadc_out_if #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_done(conv_done), .conv_abort(conv_abort),
        .next_valid(next_valid), .frame_valid(frame_valid)
    );

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int abort_cnt = 0;
    bit exp_valid = 1'b1;

    always @(posedge clk) begin
        if (!rst) begin
            if (conv_done)  done_cnt  = done_cnt + 1;
            if (conv_abort) abort_cnt = abort_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input logic [DW-1:0] val, input int n);
        logic [31:0] got, want;
        int d0, a0;
        bit fv;
        got = '0; want = '0; d0 = done_cnt; a0 = abort_cnt; fv = exp_valid;
        @(negedge clk);
        sample_in = val;
        cs_n = 1'b0;
        settle();
        chk(sdo_oe == 1'b1, "R2 enable on select", 32'(sdo_oe), 32'd1);
        chk(frame_valid == fv, "R8 frame validity", 32'(frame_valid), 32'(fv));
        got[0] = sdo;
        sample_in = ~val; // R4: late change must not reach the frame
        for (int i = 1; i <= n; i++) begin
            @(negedge clk) sclk = 1'b0;
            settle();
            if (i < 32) got[i] = sdo;
            @(negedge clk) sclk = 1'b1;
            settle();
        end
        // R3 lead zeros, R4 MSB-first data, R5 trailing zeros, R8 zeros when invalid
        for (int k = 0; k <= n && k < 32; k++)
            if (fv && k >= 2 && k < 2 + DW) want[k] = val[DW - 1 - (k - 2)];
        chk(got == want, "R4 frame bits", got, want);
        if (n >= 11) begin
            chk(done_cnt == d0 + 1, "R6 done pulse", 32'(done_cnt - d0), 32'd1);
            chk(next_valid == 1'b1, "R6 valid after done", 32'(next_valid), 32'd1);
        end
        @(negedge clk) cs_n = 1'b1;
        settle();
        chk(!sdo_oe && !sdo, "R10 quiet when deselected", {30'd0, sdo_oe, sdo}, 32'd0);
        if (n >= 11) begin
            chk(abort_cnt == a0, "R9 no abort after end", 32'(abort_cnt - a0), 32'd0);
            chk(next_valid == 1'b1, "R9 valid kept", 32'(next_valid), 32'd1);
            exp_valid = 1'b1;
        end else begin
            chk(abort_cnt == a0 + 1 && done_cnt == d0, "R7 abort pulse",
                32'(abort_cnt - a0), 32'd1);
            chk(next_valid == 1'b0, "R7 valid cleared", 32'(next_valid), 32'd0);
            exp_valid = 1'b0;
        end
    endtask

    initial begin
        #(20 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lens[9] = '{0, 1, 2, 5, 10, 11, 12, 16, 20};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1 reset state
        chk(!sdo_oe && !sdo && !conv_done && !conv_abort && next_valid,
            "R1 reset state", {27'd0, sdo_oe, sdo, conv_done, conv_abort, next_valid}, 32'd1);
        foreach (lens[j]) begin
            run_frame(10'h2A5 ^ DW'(j * 37), lens[j]);
            run_frame(10'h3FF, 16);
        end
        run_frame(10'h155, 10);
        run_frame(10'h2AA, 11);
        run_frame(10'h0F0, 16);
        for (int v = 0; v < (1 << DW); v += 7)
            run_frame(DW'(v), 16);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule